// File: doc/BRIEF.md
# Branch Delay Slot Annul Unit

This unit sits beside the branch resolution stage of a pipeline that has exactly one delay slot after every branch. When a branch resolves, it decides whether the instruction in that slot retires or is squashed. It emits a one-cycle kill strobe or a one-cycle commit strobe for the slot, never both.

Each branch carries an annul bit. When the bit is clear, the branch is a delayed branch and its slot always retires. When the bit is set, its meaning depends on a static style input. In style 0 the branch squashes its slot when it falls through, which suits slots filled from the branch target. In style 1 the branch squashes its slot when it is taken, which suits slots filled from the fall-through path. Unconditional branches count as taken.

A slot instruction flagged as possibly faulting is never squashed. If a squash would otherwise happen, the unit commits the instruction and raises a fault strobe in the same cycle, so that the surrounding logic can handle it. All strobes are registered. They appear in the cycle after the edge that sampled the resolved outcome.

Top module: `dslot_annul`

## Requirements
- R1: While reset is asserted (`rst_n` low) and in the first cycle after its release, `slot_kill`, `slot_commit` and `slot_fault` are all 0.
- R2: When `slot_vld` is 0 at a sampling edge, none of the three strobes is asserted after that edge.
- R3: When `slot_vld` is 1 and `br_vld` is 0, `slot_commit` is 1 and `slot_kill` is 0 after the edge.
- R4: When `annul` is 0, the slot commits whatever the values of `taken`, `uncond` and `style`.
- R5: With `style`=0 and `annul`=1, the slot is killed when the branch is not taken and committed when it is taken.
- R6: With `style`=1 and `annul`=1, the slot is killed when the branch is taken and committed when it is not taken.
- R7: `uncond`=1 makes the branch count as taken, whatever the value of `taken`.
- R8: When `slot_may_fault`=1 and a kill would otherwise result, `slot_kill` stays 0, `slot_commit` is 1 and `slot_fault` is 1. In every other case `slot_fault` is 0.
- R9: The strobes are registered. Inputs sampled at edge N show on the outputs after edge N and hold until edge N+1. `slot_kill` and `slot_commit` are never both 1, and with `slot_vld` held for one cycle only, each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| style | input | 1 | Static annul-bit meaning: 0 means squash on not-taken, 1 means squash on taken |
| br_vld | input | 1 | A branch resolves this cycle |
| annul | input | 1 | Annul bit from the branch instruction |
| uncond | input | 1 | Branch is unconditional |
| taken | input | 1 | Resolved outcome of a conditional branch |
| slot_vld | input | 1 | The delay slot holds a real instruction |
| slot_may_fault | input | 1 | The slot instruction may raise an exception |
| slot_kill | output | 1 | Squash the slot instruction |
| slot_commit | output | 1 | Retire the slot instruction |
| slot_fault | output | 1 | A squash was refused because the slot may fault |

## Verification
The unit's only state is the three output registers. A wrong next-state value therefore shows on the ports one cycle after the sampling edge and lasts only that cycle. Each scenario samples that exact cycle, then an idle cycle after it to catch a strobe that stays high too long. An inverted style decode or a missing unconditional override changes kill into commit on one of the directed outcome combinations. A dropped fault guard shows as a kill that appears together with an asserted fault flag.

// File: rtl/dslot_annul.sv
module dslot_annul (
  input  logic clk,
  input  logic rst_n,
  input  logic style,
  input  logic br_vld,
  input  logic annul,
  input  logic uncond,
  input  logic taken,
  input  logic slot_vld,
  input  logic slot_may_fault,
  output logic slot_kill,
  output logic slot_commit,
  output logic slot_fault
);

  logic eff_taken, squash, blocked, kill_d, commit_d, fault_d;

  assign eff_taken = uncond | taken;
  assign squash    = br_vld & annul & (style ? eff_taken : ~eff_taken);
  assign blocked   = squash & slot_may_fault;
  assign kill_d    = slot_vld & squash & ~slot_may_fault;
  assign commit_d  = slot_vld & ~kill_d;
  assign fault_d   = slot_vld & blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_kill   <= 1'b0;
      slot_commit <= 1'b0;
      slot_fault  <= 1'b0;
    end else begin
      slot_kill   <= kill_d;
      slot_commit <= commit_d;
      slot_fault  <= fault_d;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_kill && slot_commit));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld |=> !slot_kill && !slot_commit && !slot_fault);

  a_r4_delayed_commits: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && !annul |=> slot_commit);

  a_r3_nobranch_commits: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && !br_vld |=> slot_commit);

  a_r8_fault_not_killed: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && slot_may_fault |=> !slot_kill);

  a_r8_fault_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |-> slot_commit);

endmodule

// File: tb/tb_dslot_annul.sv
`timescale 1ns/1ps
module tb_dslot_annul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic style = 1'b0, br_vld = 1'b0, annul = 1'b0, uncond = 1'b0, taken = 1'b0;
  logic slot_vld = 1'b0, slot_may_fault = 1'b0;
  logic slot_kill, slot_commit, slot_fault;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dslot_annul dut (
    .clk(clk), .rst_n(rst_n), .style(style), .br_vld(br_vld), .annul(annul),
    .uncond(uncond), .taken(taken), .slot_vld(slot_vld),
    .slot_may_fault(slot_may_fault), .slot_kill(slot_kill),
    .slot_commit(slot_commit), .slot_fault(slot_fault)
  );

  task automatic check(string req, logic k, logic c, logic f);
    n_chk++;
    if ({slot_kill, slot_commit, slot_fault} !== {k, c, f}) begin
      n_bad++;
      $display("FAIL %s: kill/commit/fault got %b%b%b expected %b%b%b",
               req, slot_kill, slot_commit, slot_fault, k, c, f);
    end
  endtask

  task automatic step(string req, logic st, logic bv, logic an, logic un, logic tk,
                      logic sv, logic mf, logic k, logic c, logic f);
    @(negedge clk);
    style = st; br_vld = bv; annul = an; uncond = un; taken = tk;
    slot_vld = sv; slot_may_fault = mf;
    @(posedge clk); #1;
    check(req, k, c, f);
    @(negedge clk);
    br_vld = 1'b0; slot_vld = 1'b0; slot_may_fault = 1'b0;
    @(posedge clk); #1;
    check({req, " R9 pulse"}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    slot_vld = 1'b1; br_vld = 1'b0;
    @(posedge clk); #1;
    check("R1 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    slot_vld = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_slot;
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R2", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_branch;
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R3", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_delayed;
    for (int i = 0; i < 8; i++)
      step("R4", i[0], 1'b1, 1'b0, i[1], i[2], 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_style0;
    step("R5 not taken", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5 taken",     1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_style1;
    step("R6 taken",     1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R6 not taken", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_uncond;
    step("R7 style0", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R7 style1", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fault;
    step("R8 style0 blocked", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R8 style1 blocked", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R8 no squash",      1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    style = 1'b0; br_vld = 1'b1; annul = 1'b1; uncond = 1'b0; taken = 1'b0;
    slot_vld = 1'b1; slot_may_fault = 1'b0;
    @(posedge clk); #1;
    check("R9 first", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    taken = 1'b1;
    @(posedge clk); #1;
    check("R9 second", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    br_vld = 1'b0; slot_vld = 1'b0;
    @(posedge clk); #1;
    check("R9 idle", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_slot();
    t_no_branch();
    t_delayed();
    t_style0();
    t_style1();
    t_uncond();
    t_fault();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule